// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block sets the order of bus cycles for one instruction of a processor with an 8/16-bit accumulator. A one-cycle `start` pulse loads the addressing-mode class, the access type (read, write or read-modify-write) and the operand width. From the next cycle on, the block walks through the bus cycles that the class needs. For each cycle it reports a cycle kind, an address source, and strobes that move the program counter, load the instruction buffer, step the data pointer or write.

The block makes a clear split between two program-counter reads that leave the counter unchanged. A *keep* read puts the returned byte into the instruction buffer, for example the high byte of an absolute target. A *discard* read is an internal-operation cycle. It drives the program-counter address, but the returned byte is not stored and no register moves. A `ready` input stalls the current cycle, and no strobe fires while it is stalled. A new `start` pulse restarts the walk at the first cycle, even when a walk is already under way.

Top module: `cyc_seq`

## Requirements
- R1: After reset and whenever no walk is active, `busy` is 0, `kind_o` is 0 (none) and `addr_src_o` is 0 (none), and every strobe is 0.
- R2: Cycle kind codes are: 0 none, 1 PC read+increment, 2 PC keep, 3 PC discard, 4 data read with pointer +1, 5 data read, 6 data dummy read, 7 write with pointer +1, 8 write with pointer −1, 9 write, 10 stack push. Address source codes are: 0 none, 1 PC (kinds 1–3), 2 data (kinds 4–9), 3 stack (kind 10). When `ready`=1: `pc_inc_o` fires only for kind 1; `buf_cap_o` fires for kinds 1 and 2; kind 3 fires neither.
- R3: Mode codes are: 0 implied, 1 accumulator, 2 two-cycle implied (byte swap, clock stop, interrupt wait). Modes 0 and 1 take one discard cycle, and mode 2 takes two discard cycles. Codes 11–15 behave as mode 0.
- R4: Mode 3, status-bit set/clear with an immediate operand, runs 1,3. Mode 10, long relative branch, runs 1,1,3.
- R5: The direct-page modes run these prefixes, each followed by the operand access: mode 4 direct 1,3; mode 5 direct indexed 1,3,3; mode 7 direct indirect 1,3,4,5; mode 6 direct indexed indirect 1,3,3,4,5.
- R6: Mode 8, absolute call, runs 1,2,3,10,10.
- R7: Mode 9, absolute indexed indirect jump, runs 1,2,3,4,5.
- R8: Access codes are 0 read, 1 write, 2 read-modify-write, with 3 treated as read. The operand access for modes 4–7 is as follows. Narrow (`wide_i`=0): read 5; write 9; read-modify-write 5,6,9. Wide: read 4,5; write 7,9; read-modify-write 4,5,6,8,9.
- R9: While `ready`=0, the current cycle's kind and address source are held, and `pc_inc_o`, `buf_cap_o`, `dptr_inc_o`, `dptr_dec_o` and `wr_en_o` are all 0.
- R10: When `start` is sampled at a clock edge, the first cycle of the new walk appears after that edge. This holds even when a walk is already active.
- R11: `last_o` is 1 exactly on the final cycle of a walk. When that cycle completes with `ready`=1, the block goes idle on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads the configuration and restarts the walk |
| ready | input | 1 | Bus ready; 0 stalls the current cycle |
| mode_i | input | 4 | Addressing-mode class code |
| access_i | input | 2 | Access type code |
| wide_i | input | 1 | 1 selects a 16-bit operand |
| busy | output | 1 | A walk is active |
| kind_o | output | 4 | Current cycle kind |
| addr_src_o | output | 2 | Current address source |
| pc_inc_o | output | 1 | Program counter increment strobe |
| buf_cap_o | output | 1 | Instruction buffer capture strobe |
| dptr_inc_o | output | 1 | Data pointer increment strobe |
| dptr_dec_o | output | 1 | Data pointer decrement strobe |
| wr_en_o | output | 1 | Write strobe |
| last_o | output | 1 | Final cycle of the walk |

## Verification
The first cycle kind appears one edge after `start` is sampled. Each later kind appears one edge after a cycle in which `ready` was high. The strobes are combinational from the current kind and `ready`, so they are due in the same cycle. The bench changes inputs on the falling edge and samples one nanosecond later. At each sample it compares against the entry of an independently built expected list, and it moves its own index only when it drove `ready` high. This keeps stalled cycles aligned with the held kind. The idle check comes at the sample after the final ready cycle.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

  localparam int SEQ_DEPTH = 12;
  localparam int STEP_W    = $clog2(SEQ_DEPTH);

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [3:0] {
    K_NONE     = 4'd0,
    K_PC_INC   = 4'd1,
    K_PC_KEEP  = 4'd2,
    K_PC_DISC  = 4'd3,
    K_RD_INC   = 4'd4,
    K_RD       = 4'd5,
    K_RD_DUMMY = 4'd6,
    K_WR_INC   = 4'd7,
    K_WR_DEC   = 4'd8,
    K_WR       = 4'd9,
    K_PUSH     = 4'd10
  } kind_e;

  typedef enum logic [3:0] {
    M_IMPLIED     = 4'd0,
    M_ACCUM       = 4'd1,
    M_IMPL2       = 4'd2,
    M_FLAG_IMM    = 4'd3,
    M_DIRECT      = 4'd4,
    M_DIR_IDX     = 4'd5,
    M_DIR_IDX_IND = 4'd6,
    M_DIR_IND     = 4'd7,
    M_ABS_CALL    = 4'd8,
    M_ABS_IDX_JMP = 4'd9,
    M_REL_LONG    = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    A_READ  = 2'd0,
    A_WRITE = 2'd1,
    A_RMW   = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    S_NONE  = 2'd0,
    S_PC    = 2'd1,
    S_DATA  = 2'd2,
    S_STACK = 2'd3
  } src_e;

  typedef struct packed {
    mode_e mode;
    acc_e  acc;
    logic  wide;
  } cfg_t;

  // Number of cycles before any operand access.
  function automatic step_t prefix_len(mode_e m);
    case (m)
      M_IMPL2, M_FLAG_IMM, M_DIRECT:         prefix_len = step_t'(2);
      M_DIR_IDX, M_REL_LONG:                 prefix_len = step_t'(3);
      M_DIR_IND:                             prefix_len = step_t'(4);
      M_DIR_IDX_IND, M_ABS_CALL,
      M_ABS_IDX_JMP:                         prefix_len = step_t'(5);
      default:                               prefix_len = step_t'(1);
    endcase
  endfunction

  function automatic logic has_operand(mode_e m);
    has_operand = (m == M_DIRECT) || (m == M_DIR_IDX) ||
                  (m == M_DIR_IND) || (m == M_DIR_IDX_IND);
  endfunction

  // Prefix cycle j of mode m (j below prefix_len).
  function automatic kind_e prefix_op(mode_e m, step_t j);
    prefix_op = K_PC_DISC;
    case (m)
      M_FLAG_IMM, M_DIRECT, M_DIR_IDX:
        prefix_op = (j == step_t'(0)) ? K_PC_INC : K_PC_DISC;
      M_REL_LONG:
        prefix_op = (j < step_t'(2)) ? K_PC_INC : K_PC_DISC;
      M_DIR_IND:
        case (j)
          step_t'(0): prefix_op = K_PC_INC;
          step_t'(1): prefix_op = K_PC_DISC;
          step_t'(2): prefix_op = K_RD_INC;
          default:    prefix_op = K_RD;
        endcase
      M_DIR_IDX_IND:
        case (j)
          step_t'(0): prefix_op = K_PC_INC;
          step_t'(3): prefix_op = K_RD_INC;
          step_t'(4): prefix_op = K_RD;
          default:    prefix_op = K_PC_DISC;
        endcase
      M_ABS_CALL, M_ABS_IDX_JMP:
        case (j)
          step_t'(0): prefix_op = K_PC_INC;
          step_t'(1): prefix_op = K_PC_KEEP;
          step_t'(2): prefix_op = K_PC_DISC;
          step_t'(3): prefix_op = (m == M_ABS_CALL) ? K_PUSH : K_RD_INC;
          default:    prefix_op = (m == M_ABS_CALL) ? K_PUSH : K_RD;
        endcase
      default: prefix_op = K_PC_DISC;
    endcase
  endfunction

  function automatic step_t operand_len(acc_e a, logic w);
    case (a)
      A_RMW:   operand_len = w ? step_t'(5) : step_t'(3);
      default: operand_len = w ? step_t'(2) : step_t'(1);
    endcase
  endfunction

  // Operand cycle j (j below operand_len).
  function automatic kind_e operand_op(acc_e a, logic w, step_t j);
    operand_op = K_RD;
    case (a)
      A_WRITE:
        operand_op = (w && j == step_t'(0)) ? K_WR_INC : K_WR;
      A_RMW:
        if (w) begin
          case (j)
            step_t'(0): operand_op = K_RD_INC;
            step_t'(1): operand_op = K_RD;
            step_t'(2): operand_op = K_RD_DUMMY;
            step_t'(3): operand_op = K_WR_DEC;
            default:    operand_op = K_WR;
          endcase
        end else begin
          case (j)
            step_t'(0): operand_op = K_RD;
            step_t'(1): operand_op = K_RD_DUMMY;
            default:    operand_op = K_WR;
          endcase
        end
      default:
        operand_op = (w && j == step_t'(0)) ? K_RD_INC : K_RD;
    endcase
  endfunction

  // Cycle kind at position idx of a whole walk; K_NONE past its end.
  function automatic kind_e op_at(cfg_t c, step_t idx);
    step_t plen;
    step_t rel;
    plen = prefix_len(c.mode);
    rel  = idx - plen;
    if (idx < plen)
      op_at = prefix_op(c.mode, idx);
    else if (has_operand(c.mode) && rel < operand_len(c.acc, c.wide))
      op_at = operand_op(c.acc, c.wide, rel);
    else
      op_at = K_NONE;
  endfunction

endpackage

// File: rtl/cyc_step_ctrl.sv
module cyc_step_ctrl
  import cyc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  ready,
  input  cfg_t  cfg_in,
  input  logic  last,
  output logic  active,
  output step_t step,
  output cfg_t  cfg_q
);

  localparam step_t STEP_ONE = step_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      cfg_q  <= '{mode: M_IMPLIED, acc: A_READ, wide: 1'b0};
    end else if (start) begin
      active <= 1'b1;
      step   <= '0;
      cfg_q  <= cfg_in;
    end else if (active && ready) begin
      if (last) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + STEP_ONE;
      end
    end
  end

endmodule

// File: rtl/cyc_op_table.sv
module cyc_op_table
  import cyc_seq_pkg::*;
(
  input  logic  active,
  input  step_t step,
  input  cfg_t  cfg,
  output kind_e kind,
  output logic  last
);

  localparam step_t STEP_ONE = step_t'(1);
  localparam step_t STEP_TOP = step_t'(SEQ_DEPTH - 1);

  kind_e next_kind;

  always_comb begin
    kind      = active ? op_at(cfg, step) : K_NONE;
    next_kind = (step == STEP_TOP) ? K_NONE : op_at(cfg, step + STEP_ONE);
    last      = active && (next_kind == K_NONE);
  end

endmodule

// File: rtl/cyc_bus_decode.sv
module cyc_bus_decode
  import cyc_seq_pkg::*;
(
  input  kind_e kind,
  input  logic  ready,
  output src_e  src,
  output logic  pc_inc,
  output logic  buf_cap,
  output logic  dptr_inc,
  output logic  dptr_dec,
  output logic  wr_en
);

  logic inc_raw, cap_raw, dinc_raw, ddec_raw, wr_raw;

  always_comb begin
    src      = S_NONE;
    inc_raw  = 1'b0;
    cap_raw  = 1'b0;
    dinc_raw = 1'b0;
    ddec_raw = 1'b0;
    wr_raw   = 1'b0;
    case (kind)
      K_PC_INC:   begin src = S_PC;    inc_raw = 1'b1; cap_raw = 1'b1; end
      K_PC_KEEP:  begin src = S_PC;    cap_raw = 1'b1;                 end
      K_PC_DISC:  begin src = S_PC;                                    end
      K_RD_INC:   begin src = S_DATA;  dinc_raw = 1'b1;                end
      K_RD,
      K_RD_DUMMY: begin src = S_DATA;                                  end
      K_WR_INC:   begin src = S_DATA;  dinc_raw = 1'b1; wr_raw = 1'b1; end
      K_WR_DEC:   begin src = S_DATA;  ddec_raw = 1'b1; wr_raw = 1'b1; end
      K_WR:       begin src = S_DATA;  wr_raw = 1'b1;                  end
      K_PUSH:     begin src = S_STACK; wr_raw = 1'b1;                  end
      default:    src = S_NONE;
    endcase
    // A stalled cycle repeats on the bus but commits nothing.
    pc_inc   = inc_raw  & ready;
    buf_cap  = cap_raw  & ready;
    dptr_inc = dinc_raw & ready;
    dptr_dec = ddec_raw & ready;
    wr_en    = wr_raw   & ready;
  end

endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
  import cyc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ready,
  input  logic [3:0] mode_i,
  input  logic [1:0] access_i,
  input  logic       wide_i,
  output logic       busy,
  output logic [3:0] kind_o,
  output logic [1:0] addr_src_o,
  output logic       pc_inc_o,
  output logic       buf_cap_o,
  output logic       dptr_inc_o,
  output logic       dptr_dec_o,
  output logic       wr_en_o,
  output logic       last_o
);

  cfg_t  cfg_in;
  cfg_t  cfg_q;
  step_t step_q;
  logic  active;
  logic  last_w;
  kind_e kind_w;
  src_e  src_w;

  always_comb begin
    cfg_in.mode = mode_e'(mode_i);
    cfg_in.acc  = (access_i == 2'd3) ? A_READ : acc_e'(access_i);
    cfg_in.wide = wide_i;
  end

  cyc_step_ctrl i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ready  (ready),
    .cfg_in (cfg_in),
    .last   (last_w),
    .active (active),
    .step   (step_q),
    .cfg_q  (cfg_q)
  );

  cyc_op_table i_table (
    .active (active),
    .step   (step_q),
    .cfg    (cfg_q),
    .kind   (kind_w),
    .last   (last_w)
  );

  cyc_bus_decode i_dec (
    .kind     (kind_w),
    .ready    (ready),
    .src      (src_w),
    .pc_inc   (pc_inc_o),
    .buf_cap  (buf_cap_o),
    .dptr_inc (dptr_inc_o),
    .dptr_dec (dptr_dec_o),
    .wr_en    (wr_en_o)
  );

  assign busy       = active;
  assign kind_o     = kind_w;
  assign addr_src_o = src_w;
  assign last_o     = last_w;

endmodule

// File: rtl/cyc_seq_chk.sv
module cyc_seq_chk
  import cyc_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        ready,
  input logic        busy,
  input logic [3:0]  kind,
  input logic [1:0]  addr_src,
  input logic        pc_inc,
  input logic        buf_cap,
  input logic        dptr_inc,
  input logic        dptr_dec,
  input logic        wr_en,
  input logic        last,
  input step_t       step
);

  // R10
  restart_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && step == '0));

  // R9
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready && !start) |=> (step == $past(step) && kind == $past(kind)));

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !(pc_inc || buf_cap || dptr_inc || dptr_dec || wr_en));

  // R11
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && ready && !start) |=> !busy);

  // R2
  discard_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 4'd3) |-> (addr_src == 2'd1 && !buf_cap && !pc_inc));

  // R2
  increment_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> (buf_cap && addr_src == 2'd1));

  // R1
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (kind == 4'd0 && addr_src == 2'd0 && !last));

endmodule

bind cyc_seq cyc_seq_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ready    (ready),
  .busy     (busy),
  .kind     (kind_o),
  .addr_src (addr_src_o),
  .pc_inc   (pc_inc_o),
  .buf_cap  (buf_cap_o),
  .dptr_inc (dptr_inc_o),
  .dptr_dec (dptr_dec_o),
  .wr_en    (wr_en_o),
  .last     (last_o),
  .step     (step_q)
);

// File: tb/test_cyc_seq.sv
`timescale 1ns/1ps
module test_cyc_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ready = 1'b0;
  logic [3:0] mode_i = '0;
  logic [1:0] access_i = '0;
  logic       wide_i = 1'b0;
  logic       busy;
  logic [3:0] kind_o;
  logic [1:0] addr_src_o;
  logic       pc_inc_o, buf_cap_o, dptr_inc_o, dptr_dec_o, wr_en_o, last_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cyc_seq i_cyc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .mode_i(mode_i), .access_i(access_i), .wide_i(wide_i),
    .busy(busy), .kind_o(kind_o), .addr_src_o(addr_src_o),
    .pc_inc_o(pc_inc_o), .buf_cap_o(buf_cap_o), .dptr_inc_o(dptr_inc_o),
    .dptr_dec_o(dptr_dec_o), .wr_en_o(wr_en_o), .last_o(last_o)
  );

  // Expected prefixes as nibble strings, first cycle in the lowest nibble.
  function automatic logic [31:0] pre_code(int m);
    case (m)
      2:  return 32'h33;
      3:  return 32'h31;
      4:  return 32'h31;
      5:  return 32'h331;
      6:  return 32'h54331;
      7:  return 32'h5431;
      8:  return 32'hAA321;
      9:  return 32'h54321;
      10: return 32'h311;
      default: return 32'h3;
    endcase
  endfunction

  function automatic int pre_len(int m);
    case (m)
      2, 3, 4: return 2;
      5, 10:   return 3;
      7:       return 4;
      6, 8, 9: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] opd_code(int a, int w);
    if (a == 1) return w ? 32'h97 : 32'h9;
    if (a == 2) return w ? 32'h98654 : 32'h965;
    return w ? 32'h54 : 32'h5;
  endfunction

  function automatic int opd_len(int m, int a, int w);
    if (m < 4 || m > 7) return 0;
    if (a == 2) return w ? 5 : 3;
    return w ? 2 : 1;
  endfunction

  function automatic logic [3:0] exp_kind(int m, int a, int w, int i);
    int pl = pre_len(m);
    if (i < pl) return 4'((pre_code(m) >> (4 * i)) & 32'hF);
    return 4'((opd_code(a, w) >> (4 * (i - pl))) & 32'hF);
  endfunction

  // {src[1:0], pc_inc, cap, dinc, ddec, wr}
  function automatic logic [6:0] exp_ctl(logic [3:0] k, logic r);
    logic [1:0] s;
    s = (k == 0) ? 2'd0 : (k <= 3) ? 2'd1 : (k == 10) ? 2'd3 : 2'd2;
    return {s, r & (k == 1), r & (k == 1 || k == 2), r & (k == 4 || k == 7),
            r & (k == 8), r & (k >= 7)};
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      3, 10:      return "R4";
      4, 5, 6, 7: return "R5";
      8:          return "R6";
      9:          return "R7";
      default:    return "R3";
    endcase
  endfunction

  task automatic check(logic ok, string tag, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic check_idle(string tag);
    check(busy == 1'b0 && kind_o == 4'd0 && addr_src_o == 2'd0, tag, "idle state",
          {busy, kind_o, addr_src_o}, 0);
    check({pc_inc_o, buf_cap_o, dptr_inc_o, dptr_dec_o, wr_en_o, last_o} == 6'd0,
          tag, "idle strobes", {pc_inc_o, buf_cap_o, dptr_inc_o, dptr_dec_o, wr_en_o, last_o}, 0);
  endtask

  task automatic pulse_start(int m, int a, int w);
    @(negedge clk);
    start    = 1'b1;
    ready    = 1'b0;
    mode_i   = 4'(m);
    access_i = 2'(a);
    wide_i   = w[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs a full walk; ready is high with probability pct percent.
  task automatic run_case(int m, int a, int w, int pct);
    int len;
    int idx;
    int guard;
    logic [3:0] ek;
    logic [6:0] ec;
    string tag;
    len   = pre_len(m) + opd_len(m, a, w);
    idx   = 0;
    guard = 0;
    pulse_start(m, a, w);
    while (idx < len && guard < 400) begin
      ready = ($urandom_range(0, 99) < pct);
      #1;
      ek  = exp_kind(m, (a == 3) ? 0 : a, w, idx);
      ec  = exp_ctl(ek, ready);
      tag = (idx == 0 && guard == 0) ? "R10" :
            (idx >= pre_len(m)) ? "R8" : mode_tag(m);
      check(busy && kind_o == ek, tag, "cycle kind", kind_o, ek);
      check({addr_src_o, pc_inc_o, buf_cap_o, dptr_inc_o, dptr_dec_o, wr_en_o} == ec,
            ready ? "R2" : "R9", "bus controls",
            {addr_src_o, pc_inc_o, buf_cap_o, dptr_inc_o, dptr_dec_o, wr_en_o}, ec);
      if (ready) begin
        check(last_o == (idx == len - 1), "R11", "last flag", last_o, idx == len - 1);
        idx++;
      end
      guard++;
      @(negedge clk);
    end
    ready = 1'b0;
    #1;
    check_idle("R11");
  endtask

  initial begin
    #1_900_000;
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_idle("R1");

    // Every class, full speed, narrow read.
    for (int m = 0; m <= 12; m++) run_case(m, 0, 0, 100);
    // Operand access variants on the direct-page modes.
    for (int m = 4; m <= 7; m++)
      for (int a = 0; a <= 3; a++)
        for (int w = 0; w <= 1; w++) run_case(m, a, w, 100);
    // Heavy stalls.
    run_case(8, 0, 0, 25);
    run_case(6, 2, 1, 20);
    // Restart in mid-walk: two cycles of a call, then a new walk.
    pulse_start(8, 0, 0);
    ready = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b1, "R10", "busy before restart", busy, 1);
    run_case(9, 0, 0, 100);
    pulse_start(6, 2, 1);
    ready = 1'b1;
    repeat (4) @(negedge clk);
    run_case(2, 0, 0, 60);
    // Constrained random.
    for (int n = 0; n < 80; n++)
      run_case($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 1),
               $urandom_range(30, 100));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule